// File: doc/BRIEF.md
# Crystal-Rate Reference Strobe and Time Base Generator

This block runs on a 75 kHz crystal-rate clock. From it, the block makes two timing signals for a tuning synthesizer. The first is a reference strobe: a pulse one clock wide that repeats at one of eight rates, picked by a 3-bit select. Each rate is an integer fraction of the input clock. Some of the rates are fractional kHz values, so the divide ratios are not powers of two.

The second signal is a slow time base at 8 Hz with 40% high time. A small output port carries a data word. When the time-base enable is set, one chosen bit of that port carries the time base and its data bit is ignored.

A new select value is taken into use only when the running period ends. Because of this, a select change never shortens or lengthens a strobe period that has already started. The serial loader that writes the select and port bits sits outside this block, and so does the oscillator.

Top module: `xtal_ref_timebase`

## Requirements
- R1: The select code sets the number of clock cycles between strobes: 0→75, 1→25, 2→15, 3→24, 4→12, 5→6, 6→5, 7→3. These give 1, 3, 5, 3.125, 6.25, 12.5, 15 and 25 kHz from 75 kHz.
- R2: `ref_stb` is high for exactly one clock cycle per period.
- R3: A change of `ref_sel` takes effect only at the wrap of the divider. The period in progress completes with the old ratio, and the next period uses the select value present at the wrap edge.
- R4: While `rst` is high, `ref_stb` is low and both dividers are held at zero. After `rst` falls, the first strobe follows the N-th rising edge, where N is the ratio of the select value held during reset.
- R5: `tbase` repeats every 9375 cycles.
- R6: `tbase` is high for 3750 cycles of each period. It is low during reset, rises at the first edge after reset and falls at the 3750th edge.
- R7: With `tb_en` = 1, `port_out[0]` equals `tbase` and does not depend on `port_data[0]`.
- R8: With `tb_en` = 0, `port_out[0]` equals `port_data[0]`. Bits 5..1 of `port_out` always equal the same bits of `port_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz crystal-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_sel | input | 3 | Reference rate select code |
| tb_en | input | 1 | Route time base onto port bit 0 |
| port_data | input | 6 | Output port data bits |
| ref_stb | output | 1 | One-cycle reference strobe |
| tbase | output | 1 | 8 Hz, 40% duty time base |
| port_out | output | 6 | Output port after time-base override |

## Verification
The collision that matters is a select change landing in the same cycle as the divider's terminal count. The bench provokes it by watching for a strobe, counting the old ratio minus one cycles, and then changing `ref_sel` just before the wrap edge. It also runs the opposite case, where the select changes right after a wrap. In both cases the bench measures the spacing of the next two strobes in edges and compares it with the old ratio and then the new one.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

   localparam int NUM_RATES = 8;
   localparam int SEL_W     = $clog2(NUM_RATES);

   // reference rate in Hz for each select code; order is the select encoding
   function automatic int rate_hz(input int idx);
      case (idx)
         0: return 1000;
         1: return 3000;
         2: return 5000;
         3: return 3125;
         4: return 6250;
         5: return 12500;
         6: return 15000;
         default: return 25000;
      endcase
   endfunction

   function automatic int ratio_for(input int clk_hz, input int idx);
      return clk_hz / rate_hz(idx);
   endfunction

   function automatic int max_ratio(input int clk_hz);
      int m;
      m = 0;
      for (int i = 0; i < NUM_RATES; i++)
         if (ratio_for(clk_hz, i) > m) m = ratio_for(clk_hz, i);
      return m;
   endfunction

   function automatic int min_ratio(input int clk_hz);
      int m;
      m = ratio_for(clk_hz, 0);
      for (int i = 1; i < NUM_RATES; i++)
         if (ratio_for(clk_hz, i) < m) m = ratio_for(clk_hz, i);
      return m;
   endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
   import refclk_pkg::*;
#(
   parameter int CLK_HZ = 75000,
   parameter int CNT_W  = $clog2(max_ratio(CLK_HZ) + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   output logic             stb
);

   logic [CNT_W-1:0] term_tab [NUM_RATES];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_q;
   logic [CNT_W-1:0] term_nxt;
   logic             wrap;

   // terminal values (ratio - 1), one per select code
   for (genvar g = 0; g < NUM_RATES; g++) begin : g_tab
      if ((CLK_HZ % rate_hz(g)) != 0) begin : g_bad_rate
         $error("CLK_HZ not an integer multiple of rate %0d", g);
      end
      assign term_tab[g] = CNT_W'(ratio_for(CLK_HZ, g) - 1);
   end

   if (min_ratio(CLK_HZ) < 2) begin : g_bad_min
      $error("every ratio must be at least 2 for a one-cycle strobe");
   end
   if ((1 << CNT_W) <= max_ratio(CLK_HZ)) begin : g_bad_w
      $error("CNT_W too narrow for the largest ratio");
   end

   assign term_nxt = term_tab[sel];
   assign wrap     = (cnt_q == term_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         term_q <= term_nxt;
         stb    <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         term_q <= term_nxt;
         stb    <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         stb    <= 1'b0;
      end
   end

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb); // R2

   AST_STB_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      stb |-> (cnt_q == '0)); // R1

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= term_q); // R1

   AST_TERM_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(term_q)); // R3

endmodule

// File: rtl/timebase_div.sv
module timebase_div #(
   parameter int PERIOD = 9375,
   parameter int HIGH   = 3750,
   parameter int W      = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst,
   output logic tb
);

   logic [W-1:0] tcnt_q;
   logic [W-1:0] tcnt_nxt;

   if (HIGH < 1 || HIGH >= PERIOD) begin : g_bad_duty
      $error("HIGH must lie strictly inside the period");
   end
   if ((1 << W) < PERIOD) begin : g_bad_w
      $error("W too narrow for PERIOD");
   end

   assign tcnt_nxt = (tcnt_q == W'(PERIOD - 1)) ? '0 : tcnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         tcnt_q <= '0;
         tb     <= 1'b0;
      end else begin
         tcnt_q <= tcnt_nxt;
         tb     <= (tcnt_nxt < W'(HIGH));
      end
   end

   AST_TB_RANGE: assert property (@(posedge clk) disable iff (rst)
      tcnt_q < W'(PERIOD)); // R5

   AST_TB_FALL_POS: assert property (@(posedge clk) disable iff (rst)
      $fell(tb) |-> (tcnt_q == W'(HIGH))); // R6

   AST_TB_RISE_POS: assert property (@(posedge clk) disable iff (rst)
      $rose(tb) |-> (tcnt_q <= W'(1))); // R5

endmodule

// File: rtl/port_mux.sv
module port_mux #(
   parameter int NPORT  = 6,
   parameter int TB_BIT = 0
) (
   input  logic [NPORT-1:0] data,
   input  logic             tb_en,
   input  logic             tb,
   output logic [NPORT-1:0] pout
);

   if (TB_BIT < 0 || TB_BIT >= NPORT) begin : g_bad_bit
      $error("TB_BIT outside the port");
   end

   for (genvar g = 0; g < NPORT; g++) begin : g_bit
      if (g == TB_BIT) begin : g_ovr
         assign pout[g] = tb_en ? tb : data[g];
      end else begin : g_pass
         assign pout[g] = data[g];
      end
   end

endmodule

// File: rtl/xtal_ref_timebase.sv
module xtal_ref_timebase
   import refclk_pkg::*;
#(
   parameter int CLK_HZ      = 75000,
   parameter int TB_HZ       = 8,
   parameter int TB_DUTY_PCT = 40,
   parameter int NPORT       = 6,
   parameter int TB_BIT      = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] ref_sel,
   input  logic             tb_en,
   input  logic [NPORT-1:0] port_data,
   output logic             ref_stb,
   output logic             tbase,
   output logic [NPORT-1:0] port_out
);

   localparam int TB_PERIOD = CLK_HZ / TB_HZ;
   localparam int TB_HIGH   = (TB_PERIOD * TB_DUTY_PCT) / 100;

   if ((CLK_HZ % TB_HZ) != 0) begin : g_bad_tb
      $error("time base rate must divide the clock rate");
   end
   if (TB_DUTY_PCT < 1 || TB_DUTY_PCT > 99) begin : g_bad_pct
      $error("duty percentage out of range");
   end

   ref_divider #(.CLK_HZ(CLK_HZ)) i_ref (
      .clk (clk),
      .rst (rst),
      .sel (ref_sel),
      .stb (ref_stb)
   );

   timebase_div #(.PERIOD(TB_PERIOD), .HIGH(TB_HIGH)) i_tb (
      .clk (clk),
      .rst (rst),
      .tb  (tbase)
   );

   port_mux #(.NPORT(NPORT), .TB_BIT(TB_BIT)) i_mux (
      .data  (port_data),
      .tb_en (tb_en),
      .tb    (tbase),
      .pout  (port_out)
   );

endmodule

// File: tb/test_xtal_ref_timebase.sv
module test_xtal_ref_timebase;

   localparam int PERIOD = 75000 / 8;
   localparam int HIGH   = PERIOD * 40 / 100;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] ref_sel = '0;
   logic       tb_en = 1'b0;
   logic [5:0] port_data = '0;
   logic       ref_stb;
   logic       tbase;
   logic [5:0] port_out;

   int cyc = 0;
   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   xtal_ref_timebase i_xtal_ref_timebase (
      .clk       (clk),
      .rst       (rst),
      .ref_sel   (ref_sel),
      .tb_en     (tb_en),
      .port_data (port_data),
      .ref_stb   (ref_stb),
      .tbase     (tbase),
      .port_out  (port_out)
   );

   function automatic int exp_ratio(input int s);
      int r;
      case (s)
         0: r = 1000;  1: r = 3000;  2: r = 5000;  3: r = 3125;
         4: r = 6250;  5: r = 12500; 6: r = 15000; default: r = 25000;
      endcase
      return 75000 / r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int s, output int c0);
      @(negedge clk);
      rst = 1'b1;
      ref_sel = 3'(s);
      repeat (3) @(negedge clk);
      chk(ref_stb == 1'b0, "R4 strobe in reset", int'(ref_stb), 0);
      chk(tbase == 1'b0, "R6 tbase in reset", int'(tbase), 0);
      rst = 1'b0;
      c0 = cyc;
   endtask

   task automatic wait_stb(output int at);
      do @(negedge clk); while (!ref_stb);
      at = cyc;
   endtask

   task automatic wait_tb(input logic lvl, output int at);
      do @(negedge clk); while (tbase !== lvl);
      at = cyc;
   endtask

   task automatic run_all();
      int c0, t0, t1, t2, n, o, nw;
      // R1 R2 R4: every select code from reset
      for (int s = 0; s < 8; s++) begin
         n = exp_ratio(s);
         do_reset(s, c0);
         wait_stb(t0);
         chk(t0 - c0 == n, "R4 first strobe edge", t0 - c0, n);
         @(negedge clk);
         chk(ref_stb == 1'b0, "R2 strobe width", int'(ref_stb), 0);
         wait_stb(t1);
         chk(t1 - t0 == n, "R1 interval", t1 - t0, n);
         wait_stb(t2);
         chk(t2 - t1 == n, "R1 interval", t2 - t1, n);
      end
      // R3: change right after a wrap, and just before a wrap
      for (int k = 0; k < 4; k++) begin
         o  = (k % 2 == 0) ? 0 : 7;
         nw = (k % 2 == 0) ? 7 : 3;
         do_reset(o, c0);
         wait_stb(t0);
         if (k < 2) ref_sel = 3'(nw);
         else begin
            repeat (exp_ratio(o) - 1) @(negedge clk);
            ref_sel = 3'(nw);
         end
         wait_stb(t1);
         chk(t1 - t0 == exp_ratio(o), "R3 old ratio kept", t1 - t0, exp_ratio(o));
         wait_stb(t2);
         chk(t2 - t1 == exp_ratio(nw), "R3 new ratio used", t2 - t1, exp_ratio(nw));
      end
      // R5 R6 time base edges, with R7 R8 port sweep in both levels
      do_reset(5, c0);
      wait_tb(1'b1, t0);
      chk(t0 - c0 == 1, "R6 first rise", t0 - c0, 1);
      for (int lv = 0; lv < 2; lv++) begin
         for (int p = 0; p < 64; p++) begin
            for (int e = 0; e < 2; e++) begin
               port_data = 6'(p);
               tb_en = e[0];
               @(negedge clk);
               chk(port_out[5:1] == port_data[5:1], "R8 upper bits",
                   int'(port_out[5:1]), int'(port_data[5:1]));
               if (e == 1)
                  chk(port_out[0] == tbase, "R7 bit0 carries tbase",
                      int'(port_out[0]), int'(tbase));
               else
                  chk(port_out[0] == port_data[0], "R8 bit0 data",
                      int'(port_out[0]), int'(port_data[0]));
            end
         end
         if (lv == 0) begin
            wait_tb(1'b0, t1);
            chk(t1 - c0 == HIGH, "R6 first fall", t1 - c0, HIGH);
         end
      end
      wait_tb(1'b1, t1);
      chk(t1 - c0 == PERIOD, "R5 period", t1 - c0, PERIOD);
      wait_tb(1'b0, t2);
      chk(t2 - t1 == HIGH, "R6 high time", t2 - t1, HIGH);
      wait_tb(1'b1, t0);
      chk(t0 - t1 == PERIOD, "R5 period", t0 - t1, PERIOD);
   endtask

   initial begin
      bit timeout;
      timeout = 1'b0;
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule